// File: doc/BRIEF.md
# Indexed Block-Transfer Register Target on a Two-Wire Serial Bus

This block is an I2C target that owns a bank of sixteen byte-wide configuration registers. A host changes them with indexed block writes. The host addresses the target, names a starting register, states how many data bytes follow, and then sends the bytes. The block stores them at consecutive registers and the index wraps around the end of the bank.

A block read begins with a short write phase that sets the index. A repeated start follows, and the host addresses the target again for reading. The target then sends a length byte taken from a dedicated count register (register 8), followed by that many registers starting at the index. The whole bank is also exposed in parallel so that the surrounding logic can use the settings directly.

The bus lines arrive as plain inputs and pass through two-flop synchronizers running on the system clock. The target drives the data line only through an active-high pull-low enable. It does not stretch the clock.

Top module: `i2c_blk_slave`

## Requirements
- R1: The target acknowledges the address byte 0xD4 (7-bit address 0x6A, write) and the address byte 0xD5 (read) by pulling the data line low during the ninth clock of the byte.
- R2: The target does not acknowledge any other address byte. It then acknowledges nothing and changes no register until the next start condition.
- R3: In a write, the byte after the address sets the index (its low four bits). The next byte is the count X. The following X data bytes are stored at consecutive registers starting at the index, and each byte is acknowledged.
- R4: Data bytes that arrive in a write after X bytes have been stored are acknowledged but are not stored.
- R5: After each stored or transmitted data byte the index advances by one, and it wraps from 15 to 0.
- R6: After 0xD5 is acknowledged, the target first sends the value of register 8. It then sends that many registers, starting at the index set by the preceding write phase. Each byte is sent most significant bit first.
- R7: After the last counted byte, or after the host answers any byte with a not-acknowledge, the target releases the data line until the next start condition, so any further byte reads as 0xFF.
- R8: After reset, register 8 holds 16, every other register holds 0, and the data line is released.
- R9: The target begins pulling the data line low only while the synchronized clock line is low.
- R10: A stop condition releases the data line at once and ends the transfer. A start or repeated start restarts address reception. A later transfer behaves as it would from idle.
- R11: Register i appears on the parallel output at bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Level of the bus clock line |
| sdaIn | input | 1 | Level of the bus data line |
| sdaOe | output | 1 | When 1, the target pulls the data line low |
| regView | output | 128 | Parallel copy of the register bank, register i at bits [8i+7:8i] |

## Verification
The bench targets writes that run past the end of the bank and reads that start at register 15. A design without wrap-around would write outside the bank or send the wrong register. It sends more data bytes than the declared count; a design that ignored the count would overwrite the register after the block. Reads with a zero count, an early not-acknowledge, and a host that acknowledges past the count each expect a released line (0xFF). A design that kept driving would return stale register data instead. A foreign address followed by register-like bytes, and a write cut short by a stop, show whether the design ignores the bus correctly and recovers, rather than acknowledging stray bytes or losing the next transfer.

// File: rtl/i2c_blk_pkg.sv
package i2c_blk_pkg;

  // Strobes from the control FSM to the register datapath
  typedef struct packed {
    logic       loadIndex;   // index <= data
    logic       loadWrCount; // remaining <= data
    logic       writeData;   // bank[index] <= data, advance
    logic       loadRdCount; // remaining <= count register
    logic       takeRead;    // advance after a transmitted byte
    logic [7:0] data;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    BUS_IDLE, BUS_RX, BUS_RXACK, BUS_TX, BUS_TXACK, BUS_IGNORE
  } busState_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_INDEX, PH_COUNT, PH_WDATA
  } phase_t;

endpackage

// File: rtl/i2c_blk_data.sv
module i2c_blk_data
  import i2c_blk_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CNT_REG   = 8,
  parameter int CNT_RESET = 16,
  localparam int IW       = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  output logic [7:0]         curByte,
  output logic [7:0]         countByte,
  output logic               countZero,
  output logic [IW-1:0]      curIndex,
  output logic [DEPTH*8-1:0] regView
);

  logic [7:0]    bank [DEPTH];
  logic [IW-1:0] index;
  logic [7:0]    remaining;
  logic          advance;

  assign advance = strobes.writeData || strobes.takeRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++)
        bank[i] <= (i == CNT_REG) ? 8'(CNT_RESET) : 8'h00;
    end else if (strobes.writeData) begin
      bank[index] <= strobes.data;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      index     <= '0;
      remaining <= '0;
    end else begin
      if (strobes.loadIndex)    index <= strobes.data[IW-1:0];
      else if (advance)         index <= index + 1'b1;
      if (strobes.loadWrCount)  remaining <= strobes.data;
      else if (strobes.loadRdCount) remaining <= bank[CNT_REG];
      else if (advance)         remaining <= remaining - 8'd1;
    end
  end

  assign curByte   = bank[index];
  assign countByte = bank[CNT_REG];
  assign countZero = (remaining == 8'd0);
  assign curIndex  = index;

  for (genvar g = 0; g < DEPTH; g++) begin : gView
    assign regView[g*8 +: 8] = bank[g];
  end

endmodule

// File: rtl/i2c_blk_ctrl.sv
module i2c_blk_ctrl
  import i2c_blk_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  logic [7:0]   curByte,
  input  logic [7:0]   countByte,
  input  logic         countZero,
  output logic         sdaOe,
  output logic         sclLevel,
  output logic         sdaLevel,
  output ctrlStrobes_t strobes
);

  logic [1:0] sclS, sdaS;
  logic       sclP, sdaP;
  logic       sclQ, sdaQ;
  logic       startDet, stopDet, sclRise, sclFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclS <= 2'b11;
      sdaS <= 2'b11;
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclS <= {sclS[0], sclIn};
      sdaS <= {sdaS[0], sdaIn};
      sclP <= sclS[1];
      sdaP <= sdaS[1];
    end
  end

  assign sclQ     = sclS[1];
  assign sdaQ     = sdaS[1];
  assign sclLevel = sclQ;
  assign sdaLevel = sdaQ;
  assign startDet = sclQ && sclP && sdaP && !sdaQ;
  assign stopDet  = sclQ && sclP && !sdaP && sdaQ;
  assign sclRise  = sclQ && !sclP;
  assign sclFall  = !sclQ && sclP;

  busState_t  state;
  phase_t     phase;
  logic [2:0] bitCnt;
  logic [7:0] shReg;
  logic       ackOn, ackPhase, readMode, lastBit, sdaOeR;
  logic [7:0] rxFull;
  logic       byteDone;

  assign rxFull   = {shReg[6:0], sdaQ};
  assign byteDone = (state == BUS_RX) && sclRise && (bitCnt == 3'd7);

  always_comb begin
    strobes             = '0;
    strobes.data        = rxFull;
    strobes.loadIndex   = byteDone && (phase == PH_INDEX);
    strobes.loadWrCount = byteDone && (phase == PH_COUNT);
    strobes.writeData   = byteDone && (phase == PH_WDATA) && !countZero;
    strobes.loadRdCount = byteDone && (phase == PH_ADDR) && (rxFull == {DEV_ADDR, 1'b1});
    strobes.takeRead    = (state == BUS_TXACK) && sclFall && ackPhase && ackOn && !countZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= BUS_IDLE;
      phase    <= PH_ADDR;
      bitCnt   <= '0;
      shReg    <= '0;
      ackOn    <= 1'b0;
      ackPhase <= 1'b0;
      readMode <= 1'b0;
      lastBit  <= 1'b0;
      sdaOeR   <= 1'b0;
    end else if (startDet) begin
      state    <= BUS_RX;
      phase    <= PH_ADDR;
      bitCnt   <= '0;
      readMode <= 1'b0;
      lastBit  <= 1'b0;
      sdaOeR   <= 1'b0;
    end else if (stopDet) begin
      state  <= BUS_IDLE;
      sdaOeR <= 1'b0;
    end else begin
      case (state)
        BUS_RX: if (sclRise) begin
          shReg  <= rxFull;
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            state    <= BUS_RXACK;
            ackPhase <= 1'b0;
            ackOn    <= 1'b1;
            case (phase)
              PH_ADDR: begin
                if (rxFull == {DEV_ADDR, 1'b0})      phase    <= PH_INDEX;
                else if (rxFull == {DEV_ADDR, 1'b1}) readMode <= 1'b1;
                else                                 ackOn    <= 1'b0;
              end
              PH_INDEX: phase <= PH_COUNT;
              PH_COUNT: phase <= PH_WDATA;
              default:  ;
            endcase
          end
        end
        BUS_RXACK: if (sclFall) begin
          if (!ackPhase) begin
            sdaOeR   <= ackOn;
            ackPhase <= 1'b1;
          end else if (!ackOn) begin
            sdaOeR <= 1'b0;
            state  <= BUS_IGNORE;
          end else if (readMode) begin
            shReg   <= countByte;
            sdaOeR  <= ~countByte[7];
            state   <= BUS_TX;
            bitCnt  <= '0;
            lastBit <= 1'b0;
          end else begin
            sdaOeR <= 1'b0;
            state  <= BUS_RX;
            bitCnt <= '0;
          end
        end
        BUS_TX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) lastBit <= 1'b1;
          end else if (sclFall) begin
            if (lastBit) begin
              sdaOeR   <= 1'b0;
              state    <= BUS_TXACK;
              ackPhase <= 1'b0;
              lastBit  <= 1'b0;
            end else begin
              shReg  <= {shReg[6:0], 1'b0};
              sdaOeR <= ~shReg[6];
            end
          end
        end
        BUS_TXACK: begin
          if (sclRise) begin
            ackOn    <= !sdaQ;
            ackPhase <= 1'b1;
          end else if (sclFall && ackPhase) begin
            if (ackOn && !countZero) begin
              shReg  <= curByte;
              sdaOeR <= ~curByte[7];
              state  <= BUS_TX;
              bitCnt <= '0;
            end else begin
              state <= BUS_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = sdaOeR;

endmodule

// File: rtl/i2c_blk_slave.sv
module i2c_blk_slave
  import i2c_blk_pkg::*;
#(
  parameter int         DEPTH     = 16,
  parameter int         CNT_REG   = 8,
  parameter int         CNT_RESET = 16,
  parameter logic [6:0] DEV_ADDR  = 7'h6A
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  output logic [DEPTH*8-1:0] regView
);

  localparam int IW = $clog2(DEPTH);

  ctrlStrobes_t  strobes;
  logic [7:0]    curByte, countByte;
  logic          countZero, sclLevel, sdaLevel;
  logic [IW-1:0] curIndex;

  i2c_blk_ctrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .curByte(curByte), .countByte(countByte), .countZero(countZero),
    .sdaOe(sdaOe), .sclLevel(sclLevel), .sdaLevel(sdaLevel), .strobes(strobes)
  );

  i2c_blk_data #(.DEPTH(DEPTH), .CNT_REG(CNT_REG), .CNT_RESET(CNT_RESET)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .curByte(curByte), .countByte(countByte), .countZero(countZero),
    .curIndex(curIndex), .regView(regView)
  );

endmodule

// File: rtl/i2c_blk_checker.sv
module i2c_blk_checker
  import i2c_blk_pkg::*;
#(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          sclLevel,
  input logic          sdaLevel,
  input logic          sdaOe,
  input logic          countZero,
  input ctrlStrobes_t  strobes,
  input logic [IW-1:0] curIndex
);

  // R9: pull-low begins only after a cycle where the clock line was low
  assert_sda_low_phase_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclLevel));

  // R4: nothing is stored once the declared count is used up
  assert_no_store_past_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeData |-> !countZero);

  // R10: a stop condition releases the line on the next cycle
  assert_stop_releases_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sclLevel) && sclLevel && !$past(sdaLevel) && sdaLevel) |=> !sdaOe);

  // R5: index moves by exactly one, modulo the bank size
  assert_index_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeData || strobes.takeRead) |=> (curIndex == IW'($past(curIndex) + 1'b1)));

  // R3: at most one datapath action per cycle
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadIndex, strobes.loadWrCount, strobes.writeData,
              strobes.loadRdCount, strobes.takeRead}));

endmodule

bind i2c_blk_slave i2c_blk_checker #(.IW(IW)) uChk (
  .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .sdaLevel(sdaLevel),
  .sdaOe(sdaOe), .countZero(countZero), .strobes(strobes), .curIndex(curIndex)
);

// File: tb/tb_i2c_blk_slave.sv
module tb_i2c_blk_slave;

  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclHost = 1'b1;
  logic sdaHost = 1'b1;
  logic sdaOe;
  logic [127:0] regView;
  logic sdaLine;

  assign sdaLine = sdaHost & ~sdaOe;

  always #4 clk = ~clk;  // 125 MHz

  i2c_blk_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclHost), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .regView(regView)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int         expReq[$];
  logic [7:0] expVal[$];
  logic [7:0] obsVal[$];
  logic [7:0] model[16];
  logic [7:0] wbuf[8];

  // scoreboard monitor: pairs expected and observed items in order
  always @(negedge clk) begin
    while (expVal.size() > 0 && obsVal.size() > 0) begin
      automatic int         r = expReq.pop_front();
      automatic logic [7:0] e = expVal.pop_front();
      automatic logic [7:0] a = obsVal.pop_front();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL R%0d actual %02h expected %02h", r, a, e);
      end
    end
  end

  task automatic score(input int r, input logic [7:0] e, input logic [7:0] a);
    expReq.push_back(r);
    expVal.push_back(e);
    obsVal.push_back(a);
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    sdaHost = 1'b1; qw();
    sclHost = 1'b1; qw();
    sdaHost = 1'b0; qw();
    sclHost = 1'b0; qw();
  endtask

  task automatic stopCond();
    sdaHost = 1'b0; qw();
    sclHost = 1'b1; qw();
    sdaHost = 1'b1; qw();
  endtask

  task automatic sendBit(input logic b);
    sdaHost = b; qw();
    sclHost = 1'b1; qw(); qw();
    sclHost = 1'b0; qw();
  endtask

  task automatic readBit(output logic b);
    sdaHost = 1'b1; qw();
    sclHost = 1'b1; qw();
    b = sdaLine; qw();
    sclHost = 1'b0; qw();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    readBit(b);
    acked = !b;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    sendBit(!ackIt);
  endtask

  task automatic checkBank(input int r);
    for (int i = 0; i < 16; i++) score(r, model[i], regView[i*8 +: 8]);
  endtask

  // R1 R3 R4 R5: indexed block write
  task automatic writeBlock(input logic [7:0] n, input logic [7:0] x, input int nBytes, input int r);
    logic ak;
    startCond();
    sendByte(8'hD4, ak); score(1, 8'd1, {7'd0, ak});
    sendByte(n, ak);     score(r, 8'd1, {7'd0, ak});
    sendByte(x, ak);     score(r, 8'd1, {7'd0, ak});
    for (int i = 0; i < nBytes; i++) begin
      sendByte(wbuf[i], ak);
      score(r, 8'd1, {7'd0, ak});
      if (i < int'(x)) model[(int'(n) + i) % 16] = wbuf[i];
    end
    stopCond();
  endtask

  // R6 R7: indexed block read; host acks all but the last of nData, then tail extra bytes
  task automatic readBlock(input logic [7:0] n, input int nData, input int tail, input int r);
    logic ak;
    logic [7:0] v;
    int cnt;
    cnt = int'(model[8]);
    startCond();
    sendByte(8'hD4, ak); score(1, 8'd1, {7'd0, ak});
    sendByte(n, ak);     score(r, 8'd1, {7'd0, ak});
    startCond();
    sendByte(8'hD5, ak); score(1, 8'd1, {7'd0, ak});
    recvByte(nData > 0, v);
    score(6, model[8], v);
    for (int i = 0; i < nData; i++) begin
      recvByte(i < nData - 1, v);
      score(r, (i < cnt) ? model[(int'(n) + i) % 16] : 8'hFF, v);
    end
    for (int i = 0; i < tail; i++) begin
      recvByte(1'b0, v);
      score(7, 8'hFF, v);
    end
    stopCond();
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ak;
    for (int i = 0; i < 16; i++) model[i] = (i == 8) ? 8'd16 : 8'd0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R8 R11: reset state, visible on the parallel view
    score(8, 8'd0, {7'd0, sdaOe});
    checkBank(11);

    // R3: plain block write
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    writeBlock(8'd2, 8'd3, 3, 3);
    checkBank(3);

    // R4 R5: write wraps past 15; fifth byte beyond count is discarded
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44; wbuf[4] = 8'h99;
    writeBlock(8'd14, 8'd4, 5, 4);
    checkBank(5);

    // R6: read three bytes with count register = 3
    wbuf[0] = 8'd3;
    writeBlock(8'd8, 8'd1, 1, 3);
    readBlock(8'd2, 3, 0, 6);

    // R5: read across the wrap
    wbuf[0] = 8'd2;
    writeBlock(8'd8, 8'd1, 1, 3);
    readBlock(8'd15, 2, 0, 5);

    // R7: early not-acknowledge then released line
    wbuf[0] = 8'd4;
    writeBlock(8'd8, 8'd1, 1, 3);
    readBlock(8'd14, 1, 1, 7);

    // R7: host acks past the count
    wbuf[0] = 8'd1;
    writeBlock(8'd8, 8'd1, 1, 3);
    readBlock(8'd0, 2, 0, 7);

    // R7: zero count sends only the count byte
    wbuf[0] = 8'd0;
    writeBlock(8'd8, 8'd1, 1, 3);
    readBlock(8'd3, 1, 0, 7);

    // R2: foreign address, stray bytes ignored
    startCond();
    sendByte(8'hA0, ak); score(2, 8'd0, {7'd0, ak});
    sendByte(8'h05, ak); score(2, 8'd0, {7'd0, ak});
    sendByte(8'h01, ak); score(2, 8'd0, {7'd0, ak});
    sendByte(8'h5A, ak); score(2, 8'd0, {7'd0, ak});
    stopCond();
    checkBank(2);

    // R10: transfer cut by a stop, then a clean write
    startCond();
    sendByte(8'hD4, ak); score(1, 8'd1, {7'd0, ak});
    sendByte(8'h05, ak); score(10, 8'd1, {7'd0, ak});
    stopCond();
    score(10, 8'd0, {7'd0, sdaOe});
    wbuf[0] = 8'h77;
    writeBlock(8'd6, 8'd1, 1, 10);
    checkBank(10);

    repeat (20) @(negedge clk);
    if (expVal.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items", expVal.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule